// File: doc/BRIEF.md
# Tune and Seek Command Sequencer

This block runs the command side of a receiver's tuning loop. A host writes a 16-bit target as two bytes, the low byte first. Writing the high byte while radio power is on is the start trigger. With the grid field at 0 the block performs a direct tune: it walks a 10-bit tune position one unit per clock toward the target, as long as the target lies inside the band limits. With a non-zero grid field the block performs a station search. It steps the position by the selected grid (1, 2 or 4 units for 50, 100 or 200 kHz). After each step it waits one measurement interval, then compares the field-strength code against a threshold. The search ends at the first position that qualifies, or when the next step would pass the limit held in the target.

The outcome is a 3-bit result code, a tuned flag and a one-cycle command-done pulse. The done pulse fires on every ending, so an interrupt can hang on it. The host can cancel a running command by writing to the identity register, and a drop of radio power also cancels it. The oscillator DAC and the signal measurement sit outside the block and appear only as inputs.

The controller is a five-state machine. From IDLE, a start goes to TUNE when the grid is 0 and to SEEK_STEP otherwise. TUNE stays in place while it moves and returns to IDLE on arrival, on a band error or on a DAC limit. SEEK_STEP goes to SEEK_WAIT after it moves, and to IDLE on a limit or a DAC limit. SEEK_WAIT goes to SEEK_EVAL when the interval timer expires. SEEK_EVAL goes to IDLE when a station qualifies and back to SEEK_STEP when none does. Every busy state goes to IDLE on a cancel.

Top module: `tune_seek_seq`

## Requirements
- R1: A write of the high target byte while power is on and no command runs starts a command. The target is {high byte, stored low byte}. Bits [9:0] are the position (tune) or the limit (search), and bit 15 set selects a downward search. Result code 7 is shown from the next cycle until the command ends. A high-byte write while power is off is ignored.
- R2: The result code is 1 after reset until the first command ends. It is 0 on a normal ending.
- R3: A tune whose target lies outside [band_lo, band_hi] ends at once with code 2 and the position unchanged. A search ends with code 2, keeping its last position, when the next grid step would pass the limit.
- R4: If the DAC-limit input is high when a tune or search step is due, the command ends with code 3.
- R5: A write to the identity register while busy ends the command with code 6. The same write while idle changes nothing.
- R6: Grid code 0 selects a direct tune, moving one unit per clock to the exact target. Grid codes 1, 2 and 3 select a search stepping 1, 2 or 4 units.
- R7: A search position qualifies when fs_level is at least fs_thresh and, if fs_plus5 is set, fs_boost is also high.
- R8: The tuned flag is set by a successful tune or search. It is cleared when a command starts and when power is 0.
- R9: cmd_done is a one-cycle pulse, issued on every ending (success, limit, DAC limit or cancel). On that cycle tune_pos holds the final 10-bit position.
- R10: Dropping power during a command cancels it with code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Radio power enable |
| tgt_lo_wr | input | 1 | Strobe: store wr_byte as the low target byte |
| tgt_hi_wr | input | 1 | Strobe: high target byte write (start trigger) |
| wr_byte | input | 8 | Host write data |
| id_wr | input | 1 | Strobe: write to the identity register (cancel) |
| grid_sel | input | 2 | 0 = direct tune, 1/2/3 = search step 1/2/4 units |
| fs_thresh | input | 3 | Field-strength stop threshold |
| fs_plus5 | input | 1 | Also require the +5 dB indication |
| fs_level | input | 3 | Measured field-strength code |
| fs_boost | input | 1 | Measured +5 dB indication |
| band_lo | input | 10 | Lowest legal tune position |
| band_hi | input | 10 | Highest legal tune position |
| dac_at_limit | input | 1 | Oscillator DAC is at its end of range |
| tune_pos | output | 10 | Current tune position |
| err_code | output | 3 | Result code |
| tuned | output | 1 | Station tuned flag |
| cmd_done | output | 1 | One-cycle command-end pulse |

## Verification
Most faults in the state register show up in err_code within one clock. A machine that misses IDLE stays at code 7, and one that leaves IDLE early shows 7 without any start write. A wrong step or limit decision shows in tune_pos on the cycle of cmd_done: the position is off by a grid step, or the code is 2 instead of 0. A cancel that is not honoured holds code 7 until the watchdog expires. A wrong interval count shows only as a changed search duration, so the bench checks final positions rather than cycle counts.

// File: rtl/ts_pkg.sv
package ts_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_TUNE      = 3'd1,
        ST_SEEK_STEP = 3'd2,
        ST_SEEK_WAIT = 3'd3,
        ST_SEEK_EVAL = 3'd4
    } ts_state_t;

    localparam logic [2:0] RC_OK    = 3'd0;
    localparam logic [2:0] RC_RESET = 3'd1;
    localparam logic [2:0] RC_BAND  = 3'd2;
    localparam logic [2:0] RC_DAC   = 3'd3;
    localparam logic [2:0] RC_ABORT = 3'd6;
    localparam logic [2:0] RC_BUSY  = 3'd7;
endpackage

// File: rtl/ts_step_calc.sv
module ts_step_calc #(
    parameter int POS_W = 10
) (
    input  logic [POS_W-1:0] pos,
    input  logic [1:0]       grid,
    input  logic             down,
    input  logic [POS_W-1:0] limit,
    output logic [POS_W-1:0] next_pos,
    output logic             past_limit
);
    logic [POS_W:0] step;
    logic [POS_W:0] sum;

    always_comb begin
        unique case (grid)
            2'd1:    step = (POS_W+1)'(1);
            2'd2:    step = (POS_W+1)'(2);
            2'd3:    step = (POS_W+1)'(4);
            default: step = (POS_W+1)'(1);
        endcase
        if (down) begin
            sum        = {1'b0, pos} - step;
            past_limit = sum[POS_W] || (sum[POS_W-1:0] < limit);
        end else begin
            sum        = {1'b0, pos} + step;
            past_limit = sum > {1'b0, limit};
        end
        next_pos = sum[POS_W-1:0];
    end
endmodule

// File: rtl/ts_fs_compare.sv
module ts_fs_compare #(
    parameter int FS_W = 3
) (
    input  logic [FS_W-1:0] level,
    input  logic [FS_W-1:0] thresh,
    input  logic            need_boost,
    input  logic            boost,
    output logic            found
);
    assign found = (level >= thresh) && (!need_boost || boost);
endmodule

// File: rtl/ts_meas_timer.sv
module ts_meas_timer #(
    parameter int MEAS_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(MEAS_CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= CW'(MEAS_CYC - 1);
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/tune_seek_seq.sv
module tune_seek_seq #(
    parameter int POS_W    = 10,
    parameter int FS_W     = 3,
    parameter int MEAS_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic             tgt_lo_wr,
    input  logic             tgt_hi_wr,
    input  logic [7:0]       wr_byte,
    input  logic             id_wr,
    input  logic [1:0]       grid_sel,
    input  logic [FS_W-1:0]  fs_thresh,
    input  logic             fs_plus5,
    input  logic [FS_W-1:0]  fs_level,
    input  logic             fs_boost,
    input  logic [POS_W-1:0] band_lo,
    input  logic [POS_W-1:0] band_hi,
    input  logic             dac_at_limit,
    output logic [POS_W-1:0] tune_pos,
    output logic [2:0]       err_code,
    output logic             tuned,
    output logic             cmd_done
);
    import ts_pkg::*;

    localparam int TGT_W = 16;

    ts_state_t         state, nxt_state;
    logic [7:0]        tgt_lo_q;
    logic [TGT_W-1:0]  tgt_q;
    logic [1:0]        grid_q;
    logic              busy, start, cancel;
    logic              fin, fin_tuned, move;
    logic [2:0]        fin_code;
    logic [POS_W-1:0]  tgt_pos, seek_next, move_pos;
    logic              seek_past, found, timer_exp, timer_load;

    assign tgt_pos = tgt_q[POS_W-1:0];
    assign busy    = (state != ST_IDLE);
    assign start   = (state == ST_IDLE) && tgt_hi_wr && pwr_on;
    assign cancel  = busy && (id_wr || !pwr_on);

    ts_step_calc #(.POS_W(POS_W)) u_step (
        .pos(tune_pos), .grid(grid_q), .down(tgt_q[TGT_W-1]),
        .limit(tgt_pos), .next_pos(seek_next), .past_limit(seek_past)
    );

    ts_fs_compare #(.FS_W(FS_W)) u_fs (
        .level(fs_level), .thresh(fs_thresh), .need_boost(fs_plus5),
        .boost(fs_boost), .found(found)
    );

    ts_meas_timer #(.MEAS_CYC(MEAS_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .expired(timer_exp)
    );

    // next state and ending decision
    always_comb begin
        nxt_state  = state;
        fin        = 1'b0;
        fin_code   = RC_OK;
        fin_tuned  = 1'b0;
        move       = 1'b0;
        move_pos   = tune_pos;
        timer_load = 1'b0;
        if (cancel) begin
            nxt_state = ST_IDLE;
            fin       = 1'b1;
            fin_code  = RC_ABORT;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start)
                        nxt_state = (grid_sel == 2'd0) ? ST_TUNE : ST_SEEK_STEP;
                end
                ST_TUNE: begin
                    if (tgt_pos < band_lo || tgt_pos > band_hi) begin
                        nxt_state = ST_IDLE; fin = 1'b1; fin_code = RC_BAND;
                    end else if (tune_pos == tgt_pos) begin
                        nxt_state = ST_IDLE; fin = 1'b1; fin_tuned = 1'b1;
                    end else if (dac_at_limit) begin
                        nxt_state = ST_IDLE; fin = 1'b1; fin_code = RC_DAC;
                    end else begin
                        move     = 1'b1;
                        move_pos = (tgt_pos > tune_pos) ? tune_pos + 1'b1
                                                        : tune_pos - 1'b1;
                    end
                end
                ST_SEEK_STEP: begin
                    if (dac_at_limit) begin
                        nxt_state = ST_IDLE; fin = 1'b1; fin_code = RC_DAC;
                    end else if (seek_past) begin
                        nxt_state = ST_IDLE; fin = 1'b1; fin_code = RC_BAND;
                    end else begin
                        nxt_state  = ST_SEEK_WAIT;
                        move       = 1'b1;
                        move_pos   = seek_next;
                        timer_load = 1'b1;
                    end
                end
                ST_SEEK_WAIT: begin
                    if (timer_exp) nxt_state = ST_SEEK_EVAL;
                end
                ST_SEEK_EVAL: begin
                    if (found) begin
                        nxt_state = ST_IDLE; fin = 1'b1; fin_tuned = 1'b1;
                    end else begin
                        nxt_state = ST_SEEK_STEP;
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // outputs and held registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_lo_q <= '0;
            tgt_q    <= '0;
            grid_q   <= '0;
            tune_pos <= '0;
            err_code <= RC_RESET;
            tuned    <= 1'b0;
            cmd_done <= 1'b0;
        end else begin
            cmd_done <= fin;
            if (tgt_lo_wr) tgt_lo_q <= wr_byte;
            if (start) begin
                tgt_q    <= {wr_byte, tgt_lo_q};
                grid_q   <= grid_sel;
                err_code <= RC_BUSY;
                tuned    <= 1'b0;
            end else if (fin) begin
                err_code <= fin_code;
                tuned    <= fin_tuned && pwr_on;
            end else if (!pwr_on) begin
                tuned    <= 1'b0;
            end
            if (move) tune_pos <= move_pos;
        end
    end
endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
    parameter int POS_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_on,
    input logic             tgt_hi_wr,
    input logic             id_wr,
    input logic             busy,
    input logic [POS_W-1:0] tune_pos,
    input logic [2:0]       err_code,
    input logic             tuned,
    input logic             cmd_done
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] delta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= tune_pos;
    end
    assign delta = (tune_pos > pos_q) ? tune_pos - pos_q : pos_q - tune_pos;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tgt_hi_wr && pwr_on) |=> (err_code == 3'd7)); // R1
    AST_BUSY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (err_code == 3'd7)); // R2
    AST_CANCEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && id_wr) |=> (err_code == 3'd6 && cmd_done)); // R5
    AST_POWER_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pwr_on) |=> (err_code == 3'd6)); // R10
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (tune_pos != pos_q) |-> (delta == 1 || delta == 2 || delta == 4)); // R6
    AST_TUNED_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !tuned); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R9
    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (err_code != 3'd7 && !busy)); // R9
endmodule

bind tune_seek_seq ts_checker #(.POS_W(POS_W)) u_ts_checker (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tgt_hi_wr(tgt_hi_wr),
    .id_wr(id_wr), .busy(busy), .tune_pos(tune_pos), .err_code(err_code),
    .tuned(tuned), .cmd_done(cmd_done)
);

// File: tb/tb_tune_seek_seq.sv
`timescale 1ns/1ps
module tb_tune_seek_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on = 1'b0, tgt_lo_wr = 1'b0, tgt_hi_wr = 1'b0, id_wr = 1'b0;
    logic [7:0] wr_byte = '0;
    logic [1:0] grid_sel = '0;
    logic [2:0] fs_thresh = 3'd5;
    logic       fs_plus5 = 1'b0;
    logic [2:0] fs_level;
    logic       fs_boost;
    logic [9:0] band_lo = 10'd0, band_hi = 10'd900;
    logic       dac_at_limit = 1'b0;
    logic [9:0] tune_pos;
    logic [2:0] err_code;
    logic       tuned, cmd_done;

    int errors = 0, checks = 0;
    // stations: strong at A (no boost), strong with boost at B
    int stn_a = 25, stn_b = 1023;

    always #2 clk = ~clk;

    always_comb begin
        fs_level = 3'd1; fs_boost = 1'b0;
        if (int'(tune_pos) == stn_a) fs_level = 3'd6;
        if (int'(tune_pos) == stn_b) begin fs_level = 3'd6; fs_boost = 1'b1; end
    end

    tune_seek_seq dut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tgt_lo_wr(tgt_lo_wr),
        .tgt_hi_wr(tgt_hi_wr), .wr_byte(wr_byte), .id_wr(id_wr),
        .grid_sel(grid_sel), .fs_thresh(fs_thresh), .fs_plus5(fs_plus5),
        .fs_level(fs_level), .fs_boost(fs_boost), .band_lo(band_lo),
        .band_hi(band_hi), .dac_at_limit(dac_at_limit), .tune_pos(tune_pos),
        .err_code(err_code), .tuned(tuned), .cmd_done(cmd_done)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_cmd(int tgt16);
        @(negedge clk); wr_byte = tgt16[7:0]; tgt_lo_wr = 1'b1;
        @(negedge clk); tgt_lo_wr = 1'b0; wr_byte = tgt16[15:8]; tgt_hi_wr = 1'b1;
        @(negedge clk); tgt_hi_wr = 1'b0;
    endtask

    // returns with the bench at the negedge where cmd_done is high
    task automatic wait_done(string req);
        int n = 0;
        while (!cmd_done && n < 5000) begin @(negedge clk); n++; end
        check({req, " done seen"}, int'(cmd_done), 1);
    endtask

    task automatic t_reset;
        check("R2 reset code", err_code, 1);
        check("R8 reset tuned", tuned, 0);
        check("R9 reset done", cmd_done, 0);
        check("R9 reset pos", tune_pos, 0);
    endtask

    task automatic t_tune_up;
        grid_sel = 2'd0;
        start_cmd(20);
        check("R1 busy code", err_code, 7);
        wait_done("R6 tune up");
        check("R2 tune ok code", err_code, 0);
        check("R6 tune up pos", tune_pos, 20);
        check("R8 tuned set", tuned, 1);
        @(negedge clk);
        check("R9 done one cycle", cmd_done, 0);
    endtask

    task automatic t_tune_down;
        start_cmd(5);
        check("R8 tuned cleared at start", tuned, 0);
        wait_done("R6 tune down");
        check("R6 tune down pos", tune_pos, 5);
        check("R2 tune down code", err_code, 0);
    endtask

    task automatic t_band;
        start_cmd(1000);
        wait_done("R3 band");
        check("R3 band code", err_code, 2);
        check("R3 band pos kept", tune_pos, 5);
        check("R3 band not tuned", tuned, 0);
    endtask

    task automatic t_power_off_ignore;
        pwr_on = 1'b0;
        start_cmd(30);
        repeat (3) @(negedge clk);
        check("R1 start ignored when off", err_code, 2);
        check("R1 pos unchanged when off", tune_pos, 5);
        pwr_on = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_seek_up;
        grid_sel = 2'd2;
        start_cmd(100);
        wait_done("R7 seek up");
        check("R7 seek up found pos", tune_pos, 25);
        check("R2 seek ok code", err_code, 0);
        check("R8 seek tuned", tuned, 1);
    endtask

    task automatic t_seek_limit;
        grid_sel = 2'd3; stn_a = 1023;
        start_cmd(40);
        wait_done("R3 seek limit");
        check("R3 seek limit code", err_code, 2);
        check("R6 grid 4 last pos", tune_pos, 37);
    endtask

    task automatic t_seek_boost;
        // downward search, grid 1, limit 20; A=33 strong no boost, B=31 boost
        grid_sel = 2'd1; fs_plus5 = 1'b1; stn_a = 33; stn_b = 31;
        start_cmd(16'h8000 | 20);
        wait_done("R7 boost");
        check("R7 boost stop pos", tune_pos, 31);
        check("R6 grid 1 seek code", err_code, 0);
        fs_plus5 = 1'b0; stn_a = 1023; stn_b = 1023;
    endtask

    task automatic t_dac;
        grid_sel = 2'd0; dac_at_limit = 1'b1;
        start_cmd(50);
        wait_done("R4 dac");
        check("R4 dac code", err_code, 3);
        check("R4 dac pos", tune_pos, 31);
        dac_at_limit = 1'b0;
    endtask

    task automatic t_abort_busy;
        grid_sel = 2'd1;
        start_cmd(800);
        repeat (10) @(negedge clk);
        id_wr = 1'b1; @(negedge clk); id_wr = 1'b0;
        check("R5 abort code", err_code, 6);
        check("R9 abort done", cmd_done, 1);
        check("R5 abort not tuned", tuned, 0);
    endtask

    task automatic t_abort_idle;
        int p;
        grid_sel = 2'd0;
        start_cmd(60);
        wait_done("R5 setup");
        @(negedge clk);
        p = int'(tune_pos);
        id_wr = 1'b1; @(negedge clk); id_wr = 1'b0;
        check("R5 idle abort no done", cmd_done, 0);
        @(negedge clk);
        check("R5 idle abort code kept", err_code, 0);
        check("R5 idle abort pos kept", tune_pos, p);
        check("R5 idle abort tuned kept", tuned, 1);
    endtask

    task automatic t_power_drop;
        pwr_on = 1'b0; @(negedge clk);
        check("R8 tuned cleared by power", tuned, 0);
        pwr_on = 1'b1;
        start_cmd(200);
        repeat (5) @(negedge clk);
        pwr_on = 1'b0; @(negedge clk);
        check("R10 power cancel code", err_code, 6);
        check("R10 power cancel done", cmd_done, 1);
        pwr_on = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1; pwr_on = 1'b1;
                @(negedge clk);
                t_reset();
                t_tune_up();
                t_tune_down();
                t_band();
                t_power_off_ignore();
                t_seek_up();
                t_seek_limit();
                t_seek_boost();
                t_dac();
                t_abort_busy();
                t_abort_idle();
                t_power_drop();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule